// File: doc/BRIEF.md
# Address Translation Buffer

This block keeps a small, fully associative set of recently used page mappings. Each lookup turns a 32-bit virtual address into a physical address without walking the page tables, and it also returns the page's attribute flags. Every entry is either a 4 KB mapping or a 4 MB mapping, and the two sizes can be held at the same time. The size bit of each entry sets how many virtual address bits its tag is compared on.

A mode input chooses how a miss is handled. With hardware refill, a miss raises a request to an external table walker. The block then waits for the walker's answer, installs the returned mapping and reports the translation, and the requester sees no exception. With software refill, a miss is reported at once as a miss exception. System software then writes the mapping through a fill port and retries the lookup. A flush input removes every mapping in a single cycle.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup that hits a 4 KB entry gives a response one cycle after the request, with `rsp_valid` and `rsp_hit` high. The physical address is the entry's 20-bit frame number in bits 31:12 followed by virtual address bits 11:0, and the entry's attributes are returned with it.
- R2: A 4 MB entry compares only virtual address bits 31:22. Its physical address is frame bits 19:10 in address bits 31:22, followed by virtual address bits 21:0. Low tag bits and low frame bits given at install time have no effect.
- R3: 4 KB and 4 MB entries are used side by side. A 4 KB entry compares virtual address bits 31:12, so a neighbouring 4 KB page misses.
- R4: Attribute bit 0 means writable and bit 1 means user-accessible. A write to a page that is not writable, or a user access to a page that is not user-accessible, reports status 1 (permission fault). This applies to buffer hits and to walk results, and the address and attributes are still returned. Status 0 means success.
- R5: In software refill mode (`hw_mode`=0), a miss reports status 2 (miss exception) one cycle after the request, with `rsp_hit` low, a zero address and zero attributes, and no walk request.
- R6: A write on the fill port installs a mapping, and a later lookup of that page hits.
- R7: In hardware refill mode, a miss raises `walk_req` on the next cycle with `walk_vaddr` set to the missing address. Both hold until the walker answers. No response is given in the meantime, and lookups made while `walk_req` is high are ignored.
- R8: A walker answer without a fault installs the mapping. The cycle after the answer, `walk_req` drops and a response comes out with `rsp_hit` low and the translated address. Later lookups of that page hit.
- R9: A walker answer with a fault reports status 3 (page fault) with a zero address and zero attributes, and installs nothing.
- R10: A flush invalidates every entry in one cycle. A lookup made in the same cycle as a flush is treated as a miss.
- R11: An install goes to an entry that already maps the same page if one exists. Otherwise it goes to the lowest-numbered invalid entry. Otherwise it goes to the entry under a round-robin pointer, which starts at 0 and advances only when it is used.
- R12: After reset the buffer holds no mappings, and `rsp_valid` and `walk_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_mode | input | 1 | 1 selects hardware refill, 0 selects software refill |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup comes from user privilege |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response came from a buffer entry |
| rsp_status | output | 2 | 0 ok, 1 permission fault, 2 miss exception, 3 page fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_attr | output | 6 | Page attribute flags |
| walk_req | output | 1 | Walk request, held until answered |
| walk_vaddr | output | 32 | Address to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker found no mapping |
| walk_rsp_big | input | 1 | Walked mapping is a 4 MB page |
| walk_rsp_pfn | input | 20 | Walked frame number |
| walk_rsp_attr | input | 6 | Walked attribute flags |
| fill_valid | input | 1 | Software install strobe |
| fill_vaddr | input | 32 | Virtual address of the mapping to install |
| fill_big | input | 1 | Installed mapping is a 4 MB page |
| fill_pfn | input | 20 | Installed frame number |
| fill_attr | input | 6 | Installed attribute flags |

## Verification
The assertions check the walk handshake on every cycle. They confirm that `walk_req` rises only after a lookup in hardware mode, that it holds steady with its address until it is answered, that no response appears during a walk, and that a response follows each answer. They also check that a flush-cycle lookup never hits, that page faults come only from faulting walker answers, and that the status codes agree with `rsp_hit`. Address formation for both page sizes, the permission outcomes, the choice of entry on install and round-robin eviction, and the absence of an install after a fault can only be shown by the bench's scenarios. Those scenarios compare every response with values worked out from the requirements.

// File: rtl/xb_pkg.sv
package xb_pkg;

    typedef enum logic [1:0] {
        XB_OK        = 2'd0,
        XB_PERM      = 2'd1,
        XB_MISS_EXC  = 2'd2,
        XB_PAGE_FLT  = 2'd3
    } xb_status_e;

    localparam int XB_ATTR_WR  = 0;
    localparam int XB_ATTR_USR = 1;

    function automatic logic xb_perm_bad(input logic is_wr, input logic is_usr,
                                         input logic may_wr, input logic may_usr);
        return (is_wr & ~may_wr) | (is_usr & ~may_usr);
    endfunction

endpackage

// File: rtl/xb_match.sv
module xb_match #(
    parameter int VPN_W = 20,
    parameter int LOW_W = 10
) (
    input  logic             ent_valid,
    input  logic             ent_big,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [VPN_W-1:0] query_vpn,
    output logic             hit
);
    localparam logic [VPN_W-1:0] BIG_MASK = {{(VPN_W-LOW_W){1'b1}}, {LOW_W{1'b0}}};

    logic [VPN_W-1:0] mask;

    always_comb begin
        mask = ent_big ? BIG_MASK : '1;
        hit  = ent_valid && (((ent_vpn ^ query_vpn) & mask) == '0);
    end
endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vld,
    input  logic [N-1:0]  same_page,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] idx,
    output logic          use_rr
);
    always_comb begin
        idx    = rr_ptr;
        use_rr = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                idx    = IW'(i);
                use_rr = 1'b0;
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (same_page[i]) begin
                idx    = IW'(i);
                use_rr = 1'b0;
            end
        end
    end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
    parameter int ADDR_W   = 32,
    parameter int SMALL_SH = 12,
    parameter int BIG_SH   = 22,
    parameter int ATTR_W   = 6,
    parameter int ENTRIES  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hw_mode,
    input  logic                       flush,
    input  logic                       lk_valid,
    input  logic [ADDR_W-1:0]          lk_vaddr,
    input  logic                       lk_write,
    input  logic                       lk_user,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [1:0]                 rsp_status,
    output logic [ADDR_W-1:0]          rsp_paddr,
    output logic [ATTR_W-1:0]          rsp_attr,
    output logic                       walk_req,
    output logic [ADDR_W-1:0]          walk_vaddr,
    input  logic                       walk_rsp_valid,
    input  logic                       walk_rsp_fault,
    input  logic                       walk_rsp_big,
    input  logic [ADDR_W-SMALL_SH-1:0] walk_rsp_pfn,
    input  logic [ATTR_W-1:0]          walk_rsp_attr,
    input  logic                       fill_valid,
    input  logic [ADDR_W-1:0]          fill_vaddr,
    input  logic                       fill_big,
    input  logic [ADDR_W-SMALL_SH-1:0] fill_pfn,
    input  logic [ATTR_W-1:0]          fill_attr
);
    import xb_pkg::*;

    localparam int VPN_W = ADDR_W - SMALL_SH;
    localparam int LOW_W = BIG_SH - SMALL_SH;
    localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [ADDR_W-1:0] SMALL_OFF = ADDR_W'((64'd1 << SMALL_SH) - 64'd1);
    localparam logic [ADDR_W-1:0] BIG_OFF   = ADDR_W'((64'd1 << BIG_SH) - 64'd1);

    typedef struct packed {
        logic              valid;
        logic              big;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic [IW-1:0]        rr;
        logic                 walking;
        logic [ADDR_W-1:0]    walk_va;
        logic                 walk_wr;
        logic                 walk_usr;
        logic                 rsp_valid;
        logic                 rsp_hit;
        xb_status_e           rsp_status;
        logic [ADDR_W-1:0]    rsp_paddr;
        logic [ATTR_W-1:0]    rsp_attr;
    } state_t;

    state_t q, d;

    function automatic logic [ADDR_W-1:0] frame_addr(input logic big,
                                                    input logic [VPN_W-1:0] pfn,
                                                    input logic [ADDR_W-1:0] va);
        logic [ADDR_W-1:0] m;
        m = big ? BIG_OFF : SMALL_OFF;
        return ({pfn, {SMALL_SH{1'b0}}} & ~m) | (va & m);
    endfunction

    // Tag comparison: one array for lookups, one for installs
    logic [ENTRIES-1:0] lk_hit_v;
    logic [ENTRIES-1:0] ins_hit_v;
    logic [ENTRIES-1:0] valid_v;
    logic [VPN_W-1:0]   ins_vpn;

    assign ins_vpn = q.walking ? q.walk_va[ADDR_W-1:SMALL_SH] : fill_vaddr[ADDR_W-1:SMALL_SH];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign valid_v[g] = q.ent[g].valid;

        xb_match #(.VPN_W(VPN_W), .LOW_W(LOW_W)) u_lk (
            .ent_valid (q.ent[g].valid),
            .ent_big   (q.ent[g].big),
            .ent_vpn   (q.ent[g].vpn),
            .query_vpn (lk_vaddr[ADDR_W-1:SMALL_SH]),
            .hit       (lk_hit_v[g])
        );

        xb_match #(.VPN_W(VPN_W), .LOW_W(LOW_W)) u_ins (
            .ent_valid (q.ent[g].valid),
            .ent_big   (q.ent[g].big),
            .ent_vpn   (q.ent[g].vpn),
            .query_vpn (ins_vpn),
            .hit       (ins_hit_v[g])
        );
    end

    logic [IW-1:0] vic_idx;
    logic          vic_rr;

    xb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
        .vld       (valid_v),
        .same_page (ins_hit_v),
        .rr_ptr    (q.rr),
        .idx       (vic_idx),
        .use_rr    (vic_rr)
    );

    // Priority select of the lowest hitting entry
    entry_t lk_ent;
    logic   lk_any;

    always_comb begin
        lk_ent = '0;
        lk_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_hit_v[i]) begin
                lk_ent = q.ent[i];
                lk_any = 1'b1;
            end
        end
    end

    always_comb begin
        logic   ins_go;
        entry_t ins_ent;

        d            = q;
        d.rsp_valid  = 1'b0;
        d.rsp_hit    = 1'b0;
        d.rsp_status = XB_OK;
        d.rsp_paddr  = '0;
        d.rsp_attr   = '0;
        ins_go       = 1'b0;
        ins_ent      = '0;

        if (q.walking) begin
            if (walk_rsp_valid) begin
                d.walking   = 1'b0;
                d.rsp_valid = 1'b1;
                if (walk_rsp_fault) begin
                    d.rsp_status = XB_PAGE_FLT;
                end else begin
                    d.rsp_status = xb_perm_bad(q.walk_wr, q.walk_usr,
                                               walk_rsp_attr[XB_ATTR_WR],
                                               walk_rsp_attr[XB_ATTR_USR]) ? XB_PERM : XB_OK;
                    d.rsp_paddr  = frame_addr(walk_rsp_big, walk_rsp_pfn, q.walk_va);
                    d.rsp_attr   = walk_rsp_attr;
                    ins_go       = !flush;
                    ins_ent      = '{valid: 1'b1, big: walk_rsp_big,
                                     vpn: q.walk_va[ADDR_W-1:SMALL_SH],
                                     pfn: walk_rsp_pfn, attr: walk_rsp_attr};
                end
            end
        end else begin
            if (lk_valid) begin
                if (lk_any && !flush) begin
                    d.rsp_valid  = 1'b1;
                    d.rsp_hit    = 1'b1;
                    d.rsp_status = xb_perm_bad(lk_write, lk_user,
                                               lk_ent.attr[XB_ATTR_WR],
                                               lk_ent.attr[XB_ATTR_USR]) ? XB_PERM : XB_OK;
                    d.rsp_paddr  = frame_addr(lk_ent.big, lk_ent.pfn, lk_vaddr);
                    d.rsp_attr   = lk_ent.attr;
                end else if (hw_mode) begin
                    d.walking  = 1'b1;
                    d.walk_va  = lk_vaddr;
                    d.walk_wr  = lk_write;
                    d.walk_usr = lk_user;
                end else begin
                    d.rsp_valid  = 1'b1;
                    d.rsp_status = XB_MISS_EXC;
                end
            end
            if (fill_valid && !flush) begin
                ins_go  = 1'b1;
                ins_ent = '{valid: 1'b1, big: fill_big,
                            vpn: fill_vaddr[ADDR_W-1:SMALL_SH],
                            pfn: fill_pfn, attr: fill_attr};
            end
        end

        if (ins_go) begin
            d.ent[vic_idx] = ins_ent;
            if (vic_rr) begin
                d.rr = (q.rr == IW'(ENTRIES - 1)) ? '0 : q.rr + 1'b1;
            end
        end

        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                d.ent[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid  = q.rsp_valid;
    assign rsp_hit    = q.rsp_hit;
    assign rsp_status = q.rsp_status;
    assign rsp_paddr  = q.rsp_paddr;
    assign rsp_attr   = q.rsp_attr;
    assign walk_req   = q.walking;
    assign walk_vaddr = q.walk_va;

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_mode,
    input logic              flush,
    input logic              lk_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [1:0]        rsp_status,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic              walk_req,
    input logic [ADDR_W-1:0] walk_vaddr,
    input logic              walk_rsp_valid,
    input logic              walk_rsp_fault
);
    // R7
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_rsp_valid |=> walk_req && $stable(walk_vaddr));

    // R7
    walk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !rsp_valid);

    // R7
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req) |-> $past(lk_valid && hw_mode));

    // R5
    sw_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_req && lk_valid && !hw_mode |=> !walk_req);

    // R8
    walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_rsp_valid |=> !walk_req && rsp_valid && !rsp_hit);

    // R9
    pf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status == 2'd3 |-> !rsp_hit && $past(walk_rsp_valid && walk_rsp_fault));

    // R10
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_req && lk_valid && flush |=> !rsp_hit);

    // R1
    hit_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid && rsp_status[1] == 1'b0);

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status[1] |-> rsp_paddr == '0 && rsp_attr == '0);
endmodule

bind xlat_buffer xlat_buffer_chk #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_mode        (hw_mode),
    .flush          (flush),
    .lk_valid       (lk_valid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_status     (rsp_status),
    .rsp_paddr      (rsp_paddr),
    .rsp_attr       (rsp_attr),
    .walk_req       (walk_req),
    .walk_vaddr     (walk_vaddr),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_rsp_fault (walk_rsp_fault)
);

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_mode = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_paddr;
    logic [5:0]  rsp_attr;
    logic        walk_req;
    logic [31:0] walk_vaddr;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic        walk_rsp_big = 1'b0;
    logic [19:0] walk_rsp_pfn = '0;
    logic [5:0]  walk_rsp_attr = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic        fill_big = 1'b0;
    logic [19:0] fill_pfn = '0;
    logic [5:0]  fill_attr = '0;

    always #10 clk = ~clk;

    xlat_buffer i_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_status(rsp_status),
        .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
        .walk_rsp_big(walk_rsp_big), .walk_rsp_pfn(walk_rsp_pfn), .walk_rsp_attr(walk_rsp_attr),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_big(fill_big),
        .fill_pfn(fill_pfn), .fill_attr(fill_attr)
    );

    typedef struct {
        logic        hit;
        logic [1:0]  st;
        logic [31:0] pa;
        logic [5:0]  at;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    localparam logic [1:0] ST_OK = 2'd0, ST_PERM = 2'd1, ST_MISS = 2'd2, ST_PF = 2'd3;

    // Monitor: every response is popped and compared
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected response: got hit=%0b st=%0d pa=%h, expected none",
                         rsp_hit, rsp_status, rsp_paddr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_hit !== e.hit || rsp_status !== e.st || rsp_paddr !== e.pa || rsp_attr !== e.at) begin
                    n_bad++;
                    $display("FAIL %s: got hit=%0b st=%0d pa=%h at=%h, expected hit=%0b st=%0d pa=%h at=%h",
                             e.tag, rsp_hit, rsp_status, rsp_paddr, rsp_attr, e.hit, e.st, e.pa, e.at);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, expected %h", req, act, exp);
        end
    endtask

    task automatic expect_rsp(input logic h, input logic [1:0] s, input logic [31:0] p,
                              input logic [5:0] a, input string tag);
        exp_t e;
        e.hit = h; e.st = s; e.pa = p; e.at = a; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic lookup(input logic [31:0] va, input logic wr, input logic usr, input logic fl);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr; flush = fl;
        @(negedge clk);
        lk_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic fill(input logic [31:0] va, input logic big, input logic [19:0] pfn,
                        input logic [5:0] at);
        @(negedge clk);
        fill_valid = 1'b1; fill_vaddr = va; fill_big = big; fill_pfn = pfn; fill_attr = at;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic walk_answer(input logic flt, input logic big, input logic [19:0] pfn,
                               input logic [5:0] at);
        @(negedge clk);
        walk_rsp_valid = 1'b1; walk_rsp_fault = flt; walk_rsp_big = big;
        walk_rsp_pfn = pfn; walk_rsp_attr = at;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R12 walk_req", {31'd0, walk_req}, 32'd0);

        // R5 software miss on empty buffer
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R5 R12 empty miss");
        lookup(32'h0040_1234, 1'b0, 1'b0, 1'b0);
        check("R5 no walk", {31'd0, walk_req}, 32'd0);

        // R6 R1 fill then hit on 4 KB page
        fill(32'h0040_1000, 1'b0, 20'h12345, 6'h13);
        expect_rsp(1'b1, ST_OK, 32'h1234_5ABC, 6'h13, "R1 R6 small hit");
        lookup(32'h0040_1ABC, 1'b0, 1'b1, 1'b0);

        // R2 4 MB page
        fill(32'h0800_0000, 1'b1, 20'h2AC00, 6'h02);
        expect_rsp(1'b1, ST_OK, 32'h2AD2_3456, 6'h02, "R2 big hit");
        lookup(32'h0812_3456, 1'b0, 1'b1, 1'b0);
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R2 next big region miss");
        lookup(32'h0840_0000, 1'b0, 1'b0, 1'b0);
        fill(32'h0C12_3000, 1'b1, 20'h3C0FF, 6'h03);
        expect_rsp(1'b1, ST_OK, 32'h3C00_0010, 6'h03, "R2 low bits ignored");
        lookup(32'h0C00_0010, 1'b0, 1'b0, 1'b0);

        // R4 permissions
        expect_rsp(1'b1, ST_PERM, 32'h2AD2_3456, 6'h02, "R4 write to read-only");
        lookup(32'h0812_3456, 1'b1, 1'b1, 1'b0);
        fill(32'h0000_5000, 1'b0, 20'h00077, 6'h01);
        expect_rsp(1'b1, ST_PERM, 32'h0007_7004, 6'h01, "R4 user on supervisor page");
        lookup(32'h0000_5004, 1'b0, 1'b1, 1'b0);
        expect_rsp(1'b1, ST_OK, 32'h0007_7004, 6'h01, "R4 supervisor write ok");
        lookup(32'h0000_5004, 1'b1, 1'b0, 1'b0);

        // R3 coexistence: neighbouring 4 KB page misses, big still hits
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R3 neighbour small miss");
        lookup(32'h0040_2000, 1'b0, 1'b0, 1'b0);
        expect_rsp(1'b1, ST_OK, 32'h1234_5000, 6'h13, "R3 small still hits");
        lookup(32'h0040_1000, 1'b0, 1'b0, 1'b0);

        // R10 flush
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R10 lookup with flush");
        lookup(32'h0040_1ABC, 1'b0, 1'b0, 1'b1);
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R10 small gone");
        lookup(32'h0040_1ABC, 1'b0, 1'b0, 1'b0);
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R10 big gone");
        lookup(32'h0812_3456, 1'b0, 1'b0, 1'b0);

        // R11 replacement
        for (int i = 0; i < 8; i++) begin
            fill(32'h1000_0000 + (i << 12), 1'b0, 20'h00100 + 20'(i), 6'h03);
        end
        fill(32'h1000_3000, 1'b0, 20'h00333, 6'h03);
        expect_rsp(1'b1, ST_OK, 32'h0010_0000, 6'h03, "R11 page0 kept by same-page refill");
        lookup(32'h1000_0000, 1'b0, 1'b0, 1'b0);
        fill(32'h1000_8000, 1'b0, 20'h00108, 6'h03);
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R11 rr evicts entry 0");
        lookup(32'h1000_0000, 1'b0, 1'b0, 1'b0);
        expect_rsp(1'b1, ST_OK, 32'h0010_1000, 6'h03, "R11 page1 kept");
        lookup(32'h1000_1000, 1'b0, 1'b0, 1'b0);
        expect_rsp(1'b1, ST_OK, 32'h0033_3000, 6'h03, "R11 page3 overwritten");
        lookup(32'h1000_3000, 1'b0, 1'b0, 1'b0);
        expect_rsp(1'b1, ST_OK, 32'h0010_8000, 6'h03, "R11 page8 installed");
        lookup(32'h1000_8000, 1'b0, 1'b0, 1'b0);
        fill(32'h1000_9000, 1'b0, 20'h00109, 6'h03);
        expect_rsp(1'b0, ST_MISS, 32'h0, 6'h0, "R11 rr evicts entry 1");
        lookup(32'h1000_1000, 1'b0, 1'b0, 1'b0);
        expect_rsp(1'b1, ST_OK, 32'h0010_2000, 6'h03, "R11 page2 kept");
        lookup(32'h1000_2000, 1'b0, 1'b0, 1'b0);

        // R7 R8 hardware walk
        do_flush();
        hw_mode = 1'b1;
        lookup(32'h0050_0123, 1'b1, 1'b1, 1'b0);
        check("R7 walk_req raised", {31'd0, walk_req}, 32'd1);
        check("R7 walk_vaddr", walk_vaddr, 32'h0050_0123);
        lookup(32'h0700_0000, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R7 walk_req held", {31'd0, walk_req}, 32'd1);
        check("R7 walk_vaddr held", walk_vaddr, 32'h0050_0123);
        expect_rsp(1'b0, ST_OK, 32'h0ABC_D123, 6'h03, "R8 walk result");
        walk_answer(1'b0, 1'b0, 20'h0ABCD, 6'h03);
        check("R8 walk_req dropped", {31'd0, walk_req}, 32'd0);
        expect_rsp(1'b1, ST_OK, 32'h0ABC_DFFF, 6'h03, "R8 installed hit");
        lookup(32'h0050_0FFF, 1'b0, 1'b0, 1'b0);
        check("R8 no walk on hit", {31'd0, walk_req}, 32'd0);

        // R9 page fault
        lookup(32'h0060_0000, 1'b0, 1'b1, 1'b0);
        check("R9 walk_req", {31'd0, walk_req}, 32'd1);
        expect_rsp(1'b0, ST_PF, 32'h0, 6'h0, "R9 page fault");
        walk_answer(1'b1, 1'b0, 20'h0, 6'h0);
        lookup(32'h0060_0000, 1'b0, 1'b1, 1'b0);
        check("R9 nothing installed", {31'd0, walk_req}, 32'd1);
        expect_rsp(1'b0, ST_PERM, 32'h0004_2000, 6'h01, "R4 walk result permission");
        walk_answer(1'b0, 1'b0, 20'h00042, 6'h01);

        repeat (4) @(negedge clk);
        check("scoreboard drained", 32'(sb.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule